// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Coast

This block runs on the pixel clock and turns an incoming horizontal sync of either polarity into a clean, active-high horizontal sync. A polarity-select input tells the block which level of the incoming sync is active. The sync then passes through a two-flop synchroniser and an edge detector.

In tracking mode (coast low), the output follows the incoming sync. Its rising edge is held back by a short fixed delay, and its falling edge follows the incoming trailing edge at once. In coast mode (coast high), the incoming leading edges are disregarded. The output rises on a one-cycle line-start pulse from a flywheel loop, but only when the synchronised sync is active at that moment. The output falls at whichever comes first: the incoming trailing edge, or a timeout equal to half the measured line period.

The block measures the line period continuously, as the number of pixel clocks between consecutive line-start pulses. Coast may stay high for many lines, for example when it is tied to vertical sync.

Top module: `hsync_regen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `hs_out` is 0.
- R2: With `hs_invert`=1 the incoming sync is treated as active low, and with `hs_invert`=0 as active high. `hs_out` is always active high.
- R3: With `coast`=0, `hs_out` rises 6 clocks after the clock that first samples an active incoming sync: 2 synchroniser stages, 3 delay stages and the output register. It rises only if the sync is still active then.
- R4: With `coast`=0, `hs_out` falls 3 clocks after the clock that first samples an inactive incoming sync. This is the synchroniser and output register latency, with no added delay.
- R5: With `coast`=0, `line_ref` has no effect on `hs_out`.
- R6: With `coast`=1, `hs_out` rises on the clock after a `line_ref` pulse is sampled while the synchronised sync is active. Incoming leading edges do not raise it.
- R7: With `coast`=1 and the incoming sync held active, each pulse of `hs_out` lasts floor(P/2) clocks, where P is the measured line period.
- R8: With `coast`=1, an incoming trailing edge that arrives before the timeout ends the pulse 3 clocks after it is first sampled.
- R9: With `coast`=1 and the incoming sync inactive, `hs_out` stays 0 even when `line_ref` pulses arrive.
- R10: P is the number of clocks between two consecutive `line_ref` pulses. No timeout fires until two pulses have been seen after reset.
- R11: While `coast` stays high across many lines, every `line_ref` sampled with the sync active starts exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_raw | input | 1 | Incoming horizontal sync, either polarity |
| hs_invert | input | 1 | 1 = incoming sync is active low |
| coast | input | 1 | 1 = flywheel mode, synchronous to `clk` |
| line_ref | input | 1 | One-cycle line-start pulse from the flywheel loop |
| hs_out | output | 1 | Regenerated active-high horizontal sync |

## Verification
The assertions check on every cycle the following behaviour:
- the latency of the synchroniser and of the leading-edge delay line;
- that the output is forced low once the synchronised sync is inactive;
- that in coast mode a rise happens only on a reference pulse;
- that the timeout fires only once a period is valid;
- that the period register changes only on a reference pulse.

Only the bench's scenarios can show the end-to-end effects of this timing:
- the exact six-clock rise and three-clock fall latencies seen at the ports;
- the half-period pulse width;
- the pulse count across many coasted lines;
- the mixed random sequences that toggle coast, polarity and line length against a reference model.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
    localparam int unsigned HSR_SYNC_STAGES = 2;
    localparam int unsigned HSR_LEAD_DELAY  = 3;

    typedef enum logic {
        MODE_TRACK = 1'b0,
        MODE_COAST = 1'b1
    } hsr_mode_e;
endpackage

// File: rtl/hsr_sync_edge.sv
module hsr_sync_edge #(
    parameter int unsigned SYNC_STAGES = hsr_pkg::HSR_SYNC_STAGES,
    parameter int unsigned LEAD_DELAY  = hsr_pkg::HSR_LEAD_DELAY
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic invert,
    output logic level,
    output logic lead_dly
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic [LEAD_DELAY-1:0]  lead;
    } st_t;

    st_t  st_d, st_q;
    logic lead_now;

    // Polarity is normalised before the synchroniser so that 1 always means active.
    always_comb begin
        st_d      = st_q;
        level     = st_q.sync[SYNC_STAGES-1];
        lead_now  = level & ~st_q.prev;
        lead_dly  = st_q.lead[LEAD_DELAY-1];
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], raw ^ invert};
        st_d.prev = level;
        st_d.lead = {st_q.lead[LEAD_DELAY-2:0], lead_now};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2/R4: the level seen by the edge logic is the normalised input, SYNC_STAGES clocks late.
    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level |-> $past(raw ^ invert, SYNC_STAGES));

    // R3: a delayed leading-edge pulse always traces back to an active level LEAD_DELAY clocks earlier.
    assert_lead_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lead_dly |-> $past(level, LEAD_DELAY));
endmodule

// File: rtl/hsr_line_meter.sv
module hsr_line_meter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_ref,
    output logic [CNT_W-1:0] half,
    output logic             valid
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] per;
        logic             seen;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        half  = st_q.per >> 1;
        valid = (st_q.per != '0);
        if (line_ref) begin
            st_d.cyc  = '0;
            st_d.seen = 1'b1;
            if (st_q.seen) begin
                st_d.per = (st_q.cyc == CNT_MAX) ? CNT_MAX : st_q.cyc + 1'b1;
            end
        end else if (st_q.cyc != CNT_MAX) begin
            st_d.cyc = st_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: the measured period only changes on a reference pulse.
    assert_period_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ref |=> $stable(half));

    // R10: the period becomes valid only after a reference pulse.
    assert_valid_after_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(line_ref));
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
    parameter int unsigned CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_raw,
    input  logic hs_invert,
    input  logic coast,
    input  logic line_ref,
    output logic hs_out
);
    import hsr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic             level, lead_dly, period_ok;
    logic [CNT_W-1:0] half;
    logic             set_pulse, clr_pulse, timeout;
    hsr_mode_e        mode;

    hsr_sync_edge #(
        .SYNC_STAGES(HSR_SYNC_STAGES),
        .LEAD_DELAY (HSR_LEAD_DELAY)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (hs_raw),
        .invert  (hs_invert),
        .level   (level),
        .lead_dly(lead_dly)
    );

    hsr_line_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_ref(line_ref),
        .half    (half),
        .valid   (period_ok)
    );

    always_comb begin
        st_d    = st_q;
        mode    = coast ? MODE_COAST : MODE_TRACK;
        timeout = 1'b0;
        case (mode)
            MODE_COAST: begin
                timeout   = st_q.out & period_ok & (st_q.cnt >= half);
                set_pulse = line_ref & level;
            end
            default: begin
                set_pulse = lead_dly & level;
            end
        endcase
        clr_pulse = ~level | timeout;

        if (set_pulse)      st_d.out = 1'b1;
        else if (clr_pulse) st_d.out = 1'b0;

        if (set_pulse)                         st_d.cnt = {{(CNT_W-1){1'b0}}, 1'b1};
        else if (st_q.out && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_out = st_q.out;

    // R3: a surviving delayed leading edge raises the output in tracking mode.
    assert_track_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!coast && lead_dly && level) |=> hs_out);

    // R4/R9: an inactive synchronised sync always drives the output low next clock.
    assert_low_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !level |=> !hs_out);

    // R5: in tracking mode, only a delayed leading edge can raise the output.
    assert_track_ignores_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!coast && !hs_out && !lead_dly) |=> !hs_out);

    // R6: in coast mode, the output rises only on a reference pulse.
    assert_coast_rise_only_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coast && !hs_out && !line_ref) |=> !hs_out);

    // R6: a reference pulse seen with an active sync starts a pulse.
    assert_coast_ref_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coast && line_ref && level) |=> hs_out);

    // R7: the half-period timeout ends a coasted pulse.
    assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (coast && hs_out && period_ok && st_q.cnt >= half && !line_ref) |=> !hs_out);

    // R10: no timeout before a period has been measured.
    assert_no_early_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (coast && hs_out && !period_ok && level) |=> hs_out);
endmodule

// File: tb/sim_hsync_regen.sv
module sim_hsync_regen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_raw = 1'b0, hs_invert = 1'b0, coast = 1'b0, line_ref = 1'b0;
    logic hs_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hsync_regen u0 (
        .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .hs_invert(hs_invert),
        .coast(coast), .line_ref(line_ref), .hs_out(hs_out)
    );

    // Reference pulse generator
    logic ref_en = 1'b0;
    int   ref_per = 40;
    int   ref_cnt = 0;
    always @(negedge clk) begin
        if (ref_en) begin
            if (ref_cnt >= ref_per - 1) begin
                line_ref = 1'b1;
                ref_cnt  = 0;
            end else begin
                line_ref = 1'b0;
                ref_cnt  = ref_cnt + 1;
            end
        end else begin
            line_ref = 1'b0;
            ref_cnt  = 0;
        end
    end

    // Reference model built from the requirements
    logic [5:0]  m_h;
    logic        m_out, m_seen;
    int unsigned m_cnt, m_cyc, m_per;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = '0; m_out = 0; m_seen = 0; m_cnt = 0; m_cyc = 0; m_per = 0;
        end else begin
            logic sl, ld, to, st, cl;
            sl = m_h[1];
            ld = m_h[4] & ~m_h[5];
            to = coast && m_out && (m_per != 0) && (m_cnt >= (m_per >> 1));
            st = coast ? (line_ref && sl) : (ld && sl);
            cl = !sl || to;
            if (st) m_cnt = 1;
            else if (m_out && m_cnt < 4095) m_cnt = m_cnt + 1;
            m_out = st ? 1'b1 : (cl ? 1'b0 : m_out);
            if (line_ref) begin
                if (m_seen) m_per = (m_cyc + 1 > 4095) ? 4095 : m_cyc + 1;
                m_seen = 1'b1;
                m_cyc  = 0;
            end else if (m_cyc < 4095) m_cyc = m_cyc + 1;
            m_h = {m_h[4:0], hs_raw ^ hs_invert};
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: hs_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_en = 1'b0; coast = 1'b0; hs_raw = 1'b0; hs_invert = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_ref();
        do @(posedge clk); while (!line_ref);
    endtask

    // Drive the active level at a negedge and report the negedge on which hs_out first equals val.
    task automatic edge_latency(input string req, input logic raw_val, input logic out_val, input int exp);
        int n = 0;
        hs_raw = raw_val;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (hs_out === out_val && n == 0) n = k;
        end
        check_int(req, n, exp);
    endtask

    initial begin
        #(100 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", hs_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", hs_out, 1'b0);

        // R3 and R4 latencies in tracking mode
        edge_latency("R3", 1'b1, 1'b1, 6);
        edge_latency("R4", 1'b0, 1'b0, 3);

        // R2: active-low input
        hs_invert = 1'b1; hs_raw = 1'b1;
        repeat (8) @(negedge clk);
        check("R2", hs_out, 1'b0);
        edge_latency("R2", 1'b0, 1'b1, 6);
        edge_latency("R2", 1'b1, 1'b0, 3);
        hs_invert = 1'b0; hs_raw = 1'b0;

        // R3: pulse too short to survive the delay never raises the output
        @(negedge clk); hs_raw = 1'b1;
        @(negedge clk); hs_raw = 1'b0;
        begin
            logic seen = 0;
            repeat (10) begin @(negedge clk); if (hs_out) seen = 1; end
            check("R3", seen, 1'b0);
        end

        // R5: reference pulses ignored in tracking mode
        ref_per = 17; ref_en = 1'b1;
        repeat (40) begin @(negedge clk); check("R5", hs_out, 1'b0); end
        hs_raw = 1'b1;
        repeat (10) @(negedge clk);
        repeat (40) begin @(negedge clk); check("R5", hs_out, 1'b1); end

        // R10, R6, R7: coast with the sync held active
        do_reset();
        coast = 1'b1; hs_raw = 1'b1; ref_per = 40;
        @(negedge clk); ref_en = 1'b1;
        wait_ref();
        @(negedge clk);
        check("R6", hs_out, 1'b1);
        repeat (30) @(negedge clk);
        check("R10", hs_out, 1'b1);
        wait_ref();
        begin
            int n = 0;
            @(negedge clk);
            while (hs_out && n < 100) begin n++; @(negedge clk); end
            check_int("R7", n, 20);
        end
        // R6: incoming leading edge does not raise the output while coasting
        hs_raw = 1'b0;
        repeat (4) @(negedge clk);
        hs_raw = 1'b1;
        repeat (8) @(negedge clk);
        check("R6", hs_out, line_ref);

        // R11: one pulse per line over ten lines
        wait_ref();
        begin
            int rises = 0;
            logic prev;
            @(negedge clk);
            prev = hs_out;
            for (int k = 1; k <= 400; k++) begin
                @(negedge clk);
                if (hs_out && !prev) rises++;
                prev = hs_out;
            end
            check_int("R11", rises, 10);
        end

        // R8: trailing edge ends a coasted pulse early
        wait_ref();
        @(negedge clk);
        repeat (4) @(negedge clk);
        hs_raw = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R8", hs_out, 1'b1);
        @(negedge clk);
        check("R8", hs_out, 1'b0);

        // R9: inactive sync keeps the output low through reference pulses
        repeat (100) begin @(negedge clk); check("R9", hs_out, 1'b0); end

        // Random phase against the reference model
        do_reset();
        ref_per = 50; ref_en = 1'b1;
        begin
            int s_left = 5, c_left = 300;
            for (int cyc = 0; cyc < 6000; cyc++) begin
                @(negedge clk);
                check(coast ? "R6-R9 random" : "R3-R5 random", hs_out, m_out);
                if (--s_left <= 0) begin hs_raw = ~hs_raw; s_left = $urandom_range(1, 40); end
                if (--c_left <= 0) begin coast = ~coast; c_left = $urandom_range(100, 600); end
                if (cyc == 3000) hs_invert = 1'b1;
                if (cyc % 1500 == 700) ref_per = $urandom_range(24, 90);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule